// File: doc/BRIEF.md
# Tracking Channel Bank Host Register Port

This block sits between a 16-bit host bus and a bank of identical tracking channels. Each channel gets control registers driven from the block: a code slew word, two counter preload words, and two 32-bit numerically controlled oscillator increments, one for code and one for carrier. The block also drives one-cycle load and clear strobes. Status flags from each channel come back as inputs. The block captures them into three per-channel status registers, and the host reads them through a read map that is separate from the write map at the same addresses.

A host write first lands in a one-entry input buffer. It reaches its destination at the end of the current cycle of a free-running `SEQ_LEN`-phase sequencer. A 32-bit increment takes two writes. The high word is staged first, and the low word, which must be the very next write, commits all 32 bits at once. Three shared regions change how a write is steered. A broadcast region reaches every channel. A multi region reaches only the channels enabled in a select register. A shared high-word address stages a high word for any increment, and it bypasses the input buffer, so the low word may follow in the next cycle. Global addresses hold the status latch, the test control word and the channel select. Channel `c` occupies word addresses `8*c` to `8*c+7`.

Top module: `trkbank_regif`

## Requirements
- R1: After synchronous reset, every control register, increment register, status register, strobe and `rdata_o` is zero.
- R2: A write to channel `c` at offset 0 (slew) sets that channel's slew register within `SEQ_LEN` cycles and leaves every other channel unchanged. Two commits never fall in adjacent cycles.
- R3: A write to offset 3 (carrier high) or 5 (code high) changes nothing by itself. The next write, to offset 4 (carrier low) or 6 (code low) of the same address block, loads {high, low} into the 32-bit increment in one step.
- R4: Any write other than the matching low word that arrives while a high word is staged discards it. A later low write then leaves the increment unchanged.
- R5: A write to global word `0x73` stages a high word that matches a low write to any channel, broadcast or multi address, and that low write may come on the very next bus cycle.
- R6: Writes to the broadcast block `0x60`-`0x67` (same offsets as a channel) reach all channels.
- R7: Writes to the multi block `0x68`-`0x6F` reach only the channels whose bit is set in the select register (global word `0x72`, bit `i` enables channel `i`).
- R8: Writes to offset 1 (code phase preload) and offset 2 (carrier cycle preload) take effect only while bit 3 of the test word (global `0x71`) is 1. A taken write updates the register and pulses its load strobe for exactly one cycle. Otherwise both stay as they were.
- R9: A write of any data to a channel's offset 7 clears that channel's three status registers, pulses its `aclr_o` bit, and touches no other channel.
- R10: A write of any data to global word `0x70` copies every channel's live A, B and C flag inputs into its status registers, which then hold until the next such write.
- R11: A read pulse returns, one cycle later on `rdata_o`, status A, B or C (zero-extended) at channel offsets 0, 1 and 2. Other offsets, the broadcast, multi and global regions all read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address for read and write |
| wdata_i | input | DW | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DW | Registered read data |
| flg_a_i | input | NCH*FW | Live A flags, FW bits per channel |
| flg_b_i | input | NCH*FW | Live B flags |
| flg_c_i | input | NCH*FW | Live C flags |
| slew_o | output | NCH*DW | Code slew registers |
| cph_o | output | NCH*DW | Code phase preload registers |
| ccy_o | output | NCH*DW | Carrier cycle preload registers |
| car_inc_o | output | NCH*2*DW | Carrier increment registers |
| cod_inc_o | output | NCH*2*DW | Code increment registers |
| cph_ld_o | output | NCH | Code phase load strobes |
| ccy_ld_o | output | NCH | Carrier cycle load strobes |
| aclr_o | output | NCH | Status clear strobes |

## Verification
If the staging state goes stale, a fault cannot show until the next low write commits. It then appears as a torn or missing 32-bit increment, one sequencer cycle after that write. A wrong channel mask shows on a neighbouring channel's register at the same commit. A wrong test-mode bit shows as a preload strobe that appears or goes missing. Status latch and clear faults stay hidden in internal registers until a read pulse brings them to `rdata_o` one cycle later. So the checks read back status after every latch and clear.

// File: rtl/trkr_pkg.sv
package trkr_pkg;
  // Offset bits inside one channel block; the stride is 2**OFF_W words.
  localparam int OFF_W = 3;

  typedef enum logic [2:0] {
    OF_SLEW   = 3'd0,
    OF_CPH    = 3'd1,
    OF_CCY    = 3'd2,
    OF_CAR_HI = 3'd3,
    OF_CAR_LO = 3'd4,
    OF_COD_HI = 3'd5,
    OF_COD_LO = 3'd6,
    OF_ACLR   = 3'd7
  } woff_e;

  typedef enum logic [2:0] {
    G_LATCH = 3'd0,
    G_TEST  = 3'd1,
    G_MSEL  = 3'd2,
    G_SHI   = 3'd3
  } goff_e;

  typedef enum logic [2:0] {
    RO_STA = 3'd0,
    RO_STB = 3'd1,
    RO_STC = 3'd2
  } roff_e;

  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_CHAN  = 3'd1,
    RG_ALL   = 3'd2,
    RG_MULTI = 3'd3,
    RG_GLB   = 3'd4
  } rgn_e;
endpackage

// File: rtl/trkr_wrbuf.sv
module trkr_wrbuf #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int SEQ_LEN = 7
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wr_i,
  input  logic          bypass_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cmt_o,
  output logic [AW-1:0] cmt_addr_o,
  output logic [DW-1:0] cmt_data_o
);
  localparam int PH_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SEQ_LEN - 1);

  logic [PH_W-1:0] ph_q;
  logic            pend_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;

  assign cmt_o      = pend_q && (ph_q == PH_LAST);
  assign cmt_addr_o = addr_q;
  assign cmt_data_o = data_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q   <= '0;
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (wr_i && !bypass_i) begin
        pend_q <= 1'b1;
        addr_q <= addr_i;
        data_q <= data_i;
      end else if (cmt_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R2: the sequencer never commits in two adjacent cycles
  p_commit_gap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cmt_o |=> !cmt_o);
endmodule

// File: rtl/trkr_stage.sv
module trkr_stage #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          shr_i,
  input  logic [DW-1:0] shr_data_i,
  input  logic          cmt_i,
  input  logic [AW-1:0] cmt_addr_i,
  input  logic [DW-1:0] cmt_data_i,
  input  logic          is_hi_i,
  input  logic          is_lo_i,
  output logic          fire_o,
  output logic [DW-1:0] hi_o
);
  logic          vld_q;
  logic          wild_q;
  logic [AW-1:0] key_q;
  logic [DW-1:0] hi_q;

  assign fire_o = cmt_i && is_lo_i && vld_q && (wild_q || (cmt_addr_i == key_q));
  assign hi_o   = hi_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_q  <= 1'b0;
      wild_q <= 1'b0;
      key_q  <= '0;
      hi_q   <= '0;
    end else if (shr_i) begin
      vld_q  <= 1'b1;
      wild_q <= 1'b1;
      hi_q   <= shr_data_i;
    end else if (cmt_i) begin
      if (is_hi_i) begin
        vld_q  <= 1'b1;
        wild_q <= 1'b0;
        key_q  <= cmt_addr_i + AW'(1);
        hi_q   <= cmt_data_i;
      end else begin
        vld_q  <= 1'b0;
      end
    end
  end

  // R4: any committed non-high write leaves nothing staged
  p_abort_clears_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmt_i && !is_hi_i && !shr_i) |=> !vld_q);

  // R5: the shared high address arms a wildcard stage
  p_shared_arms_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    shr_i |=> (vld_q && wild_q));
endmodule

// File: rtl/trkr_chan.sv
module trkr_chan
  import trkr_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          cmt_i,
  input  woff_e         off_i,
  input  logic [DW-1:0] data_i,
  input  logic          fire_i,
  input  logic [DW-1:0] hi_i,
  input  logic          test_en_i,
  input  logic          latch_i,
  input  logic [FW-1:0] flg_a_i,
  input  logic [FW-1:0] flg_b_i,
  input  logic [FW-1:0] flg_c_i,
  output logic [DW-1:0]   slew_o,
  output logic [DW-1:0]   cph_o,
  output logic [DW-1:0]   ccy_o,
  output logic [2*DW-1:0] car_inc_o,
  output logic [2*DW-1:0] cod_inc_o,
  output logic            cph_ld_o,
  output logic            ccy_ld_o,
  output logic            aclr_o,
  output logic [FW-1:0]   sta_o,
  output logic [FW-1:0]   stb_o,
  output logic [FW-1:0]   stc_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slew_o    <= '0;
      cph_o     <= '0;
      ccy_o     <= '0;
      car_inc_o <= '0;
      cod_inc_o <= '0;
      cph_ld_o  <= 1'b0;
      ccy_ld_o  <= 1'b0;
      aclr_o    <= 1'b0;
      sta_o     <= '0;
      stb_o     <= '0;
      stc_o     <= '0;
    end else begin
      cph_ld_o <= 1'b0;
      ccy_ld_o <= 1'b0;
      aclr_o   <= 1'b0;
      if (latch_i) begin
        sta_o <= flg_a_i;
        stb_o <= flg_b_i;
        stc_o <= flg_c_i;
      end
      if (cmt_i) begin
        case (off_i)
          OF_SLEW: slew_o <= data_i;
          OF_CPH: if (test_en_i) begin
            cph_o    <= data_i;
            cph_ld_o <= 1'b1;
          end
          OF_CCY: if (test_en_i) begin
            ccy_o    <= data_i;
            ccy_ld_o <= 1'b1;
          end
          OF_CAR_LO: if (fire_i) car_inc_o <= {hi_i, data_i};
          OF_COD_LO: if (fire_i) cod_inc_o <= {hi_i, data_i};
          OF_ACLR: begin
            sta_o  <= '0;
            stb_o  <= '0;
            stc_o  <= '0;
            aclr_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: a code increment only moves right after a matched low commit
  p_inc_on_fire_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(cod_inc_o) |-> $past(cmt_i && fire_i));

  // R8: a preload strobe implies test mode was on at the commit
  p_preload_gated_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (cph_ld_o || ccy_ld_o) |-> $past(test_en_i));

  // R9: while the clear strobe is high the status registers are empty
  p_clear_empties_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    aclr_o |-> (sta_o == '0 && stb_o == '0 && stc_o == '0));
endmodule

// File: rtl/trkbank_regif.sv
module trkbank_regif
  import trkr_pkg::*;
#(
  parameter int NCH      = 12,
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int FW       = 8,
  parameter int SEQ_LEN  = 7,
  parameter int TEST_BIT = 3,
  parameter logic [AW-1:0] ALL_BASE   = AW'('h60),
  parameter logic [AW-1:0] MULTI_BASE = AW'('h68),
  parameter logic [AW-1:0] GLB_BASE   = AW'('h70)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [NCH*FW-1:0]   flg_a_i,
  input  logic [NCH*FW-1:0]   flg_b_i,
  input  logic [NCH*FW-1:0]   flg_c_i,
  output logic [NCH*DW-1:0]   slew_o,
  output logic [NCH*DW-1:0]   cph_o,
  output logic [NCH*DW-1:0]   ccy_o,
  output logic [NCH*2*DW-1:0] car_inc_o,
  output logic [NCH*2*DW-1:0] cod_inc_o,
  output logic [NCH-1:0]      cph_ld_o,
  output logic [NCH-1:0]      ccy_ld_o,
  output logic [NCH-1:0]      aclr_o
);
  localparam int STRIDE  = 1 << OFF_W;
  localparam int CH_SPAN = NCH * STRIDE;
  localparam int CH_W    = AW - OFF_W;
  localparam logic [AW:0] CH_SPAN_L = (AW+1)'(CH_SPAN);

  function automatic rgn_e region(input logic [AW-1:0] a);
    if ({1'b0, a} < CH_SPAN_L)                          return RG_CHAN;
    else if (a[AW-1:OFF_W] == ALL_BASE[AW-1:OFF_W])     return RG_ALL;
    else if (a[AW-1:OFF_W] == MULTI_BASE[AW-1:OFF_W])   return RG_MULTI;
    else if (a[AW-1:OFF_W] == GLB_BASE[AW-1:OFF_W])     return RG_GLB;
    else                                                return RG_NONE;
  endfunction

  // ---------------- capture side ----------------
  rgn_e  in_rg;
  logic  shr;
  assign in_rg = region(addr_i);
  assign shr   = wr_i && (in_rg == RG_GLB) && (addr_i[OFF_W-1:0] == G_SHI);

  logic          cmt;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;

  trkr_wrbuf #(.AW(AW), .DW(DW), .SEQ_LEN(SEQ_LEN)) u_wrbuf (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_i       (wr_i),
    .bypass_i   (shr),
    .addr_i     (addr_i),
    .data_i     (wdata_i),
    .cmt_o      (cmt),
    .cmt_addr_o (c_addr),
    .cmt_data_o (c_data)
  );

  // ---------------- commit-side decode ----------------
  rgn_e            c_rg;
  woff_e           c_off;
  logic [CH_W-1:0] c_ch;
  logic            c_bank;
  logic            c_hi;
  logic            c_lo;
  assign c_rg   = region(c_addr);
  assign c_off  = woff_e'(c_addr[OFF_W-1:0]);
  assign c_ch   = c_addr[AW-1:OFF_W];
  assign c_bank = (c_rg == RG_CHAN) || (c_rg == RG_ALL) || (c_rg == RG_MULTI);
  assign c_hi   = c_bank && ((c_off == OF_CAR_HI) || (c_off == OF_COD_HI));
  assign c_lo   = c_bank && ((c_off == OF_CAR_LO) || (c_off == OF_COD_LO));

  logic           test_q;
  logic [NCH-1:0] msel_q;
  logic           latch;
  assign latch = cmt && (c_rg == RG_GLB) && (c_addr[OFF_W-1:0] == G_LATCH);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      test_q <= 1'b0;
      msel_q <= '0;
    end else if (cmt && c_rg == RG_GLB) begin
      if (c_addr[OFF_W-1:0] == G_TEST) test_q <= c_data[TEST_BIT];
      if (c_addr[OFF_W-1:0] == G_MSEL) msel_q <= c_data[NCH-1:0];
    end
  end

  logic          fire;
  logic [DW-1:0] hi_w;

  trkr_stage #(.AW(AW), .DW(DW)) u_stage (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .shr_i      (shr),
    .shr_data_i (wdata_i),
    .cmt_i      (cmt),
    .cmt_addr_i (c_addr),
    .cmt_data_i (c_data),
    .is_hi_i    (c_hi),
    .is_lo_i    (c_lo),
    .fire_o     (fire),
    .hi_o       (hi_w)
  );

  // ---------------- channel bank ----------------
  logic [FW-1:0] sta_w [NCH];
  logic [FW-1:0] stb_w [NCH];
  logic [FW-1:0] stc_w [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = ((c_rg == RG_CHAN) && (c_ch == CH_W'(i))) ||
                 (c_rg == RG_ALL) ||
                 ((c_rg == RG_MULTI) && msel_q[i]);

    trkr_chan #(.DW(DW), .FW(FW)) u_chan (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .cmt_i     (cmt && sel),
      .off_i     (c_off),
      .data_i    (c_data),
      .fire_i    (fire),
      .hi_i      (hi_w),
      .test_en_i (test_q),
      .latch_i   (latch),
      .flg_a_i   (flg_a_i[i*FW +: FW]),
      .flg_b_i   (flg_b_i[i*FW +: FW]),
      .flg_c_i   (flg_c_i[i*FW +: FW]),
      .slew_o    (slew_o[i*DW +: DW]),
      .cph_o     (cph_o[i*DW +: DW]),
      .ccy_o     (ccy_o[i*DW +: DW]),
      .car_inc_o (car_inc_o[i*2*DW +: 2*DW]),
      .cod_inc_o (cod_inc_o[i*2*DW +: 2*DW]),
      .cph_ld_o  (cph_ld_o[i]),
      .ccy_ld_o  (ccy_ld_o[i]),
      .aclr_o    (aclr_o[i]),
      .sta_o     (sta_w[i]),
      .stb_o     (stb_w[i]),
      .stc_o     (stc_w[i])
    );
  end

  // ---------------- read path ----------------
  rgn_e            rd_rg;
  logic [CH_W-1:0] rd_ch;
  logic [DW-1:0]   rsel;
  assign rd_rg = in_rg;
  assign rd_ch = addr_i[AW-1:OFF_W];

  always_comb begin
    rsel = '0;
    if (rd_rg == RG_CHAN) begin
      for (int i = 0; i < NCH; i++) begin
        if (rd_ch == CH_W'(i)) begin
          case (roff_e'(addr_i[OFF_W-1:0]))
            RO_STA:  rsel = DW'(sta_w[i]);
            RO_STB:  rsel = DW'(stb_w[i]);
            RO_STC:  rsel = DW'(stc_w[i]);
            default: rsel = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     rdata_o <= '0;
    else if (rd_i) rdata_o <= rsel;
  end

  // R11: reads outside the channel region return zero
  p_rd_outside_zero_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && rd_rg != RG_CHAN) |=> (rdata_o == '0));

  // R7: a multi-region commit never reaches an unselected channel's clear strobe
  p_multi_respects_sel_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmt && c_rg == RG_MULTI && c_off == OF_ACLR) |=> ((aclr_o & ~msel_q) == '0));
endmodule

// File: tb/trkbank_regif_tb.sv
`timescale 1ns/1ps
module trkbank_regif_tb;
  localparam int NCH = 12;
  localparam int DW  = 16;
  localparam int AW  = 8;
  localparam int FW  = 8;
  localparam int GAP = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst;
  logic [AW-1:0]       addr;
  logic [DW-1:0]       wdata;
  logic                wr, rd;
  logic [DW-1:0]       rdata;
  logic [NCH*FW-1:0]   fa, fb, fc;
  logic [NCH*DW-1:0]   slew, cph, ccy;
  logic [NCH*2*DW-1:0] cinc, kinc;
  logic [NCH-1:0]      cph_ld, ccy_ld, aclr;

  trkbank_regif u_dut (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .flg_a_i(fa), .flg_b_i(fb), .flg_c_i(fc),
    .slew_o(slew), .cph_o(cph), .ccy_o(ccy), .car_inc_o(cinc), .cod_inc_o(kinc),
    .cph_ld_o(cph_ld), .ccy_ld_o(ccy_ld), .aclr_o(aclr)
  );

  int n_chk = 0, n_bad = 0;
  int n_cph5 = 0, n_ccy6 = 0, n_clr3 = 0, n_clr4 = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (cph_ld[5]) n_cph5++;
      if (ccy_ld[6]) n_ccy6++;
      if (aclr[3])   n_clr3++;
      if (aclr[4])   n_clr4++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] field(input int kind, input int ch);
    case (kind)
      0: return {16'h0, slew[ch*DW +: DW]};
      1: return kinc[ch*2*DW +: 2*DW];
      2: return cinc[ch*2*DW +: 2*DW];
      3: return {16'h0, cph[ch*DW +: DW]};
      default: return {16'h0, ccy[ch*DW +: DW]};
    endcase
  endfunction

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic bus_wr_pair(input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                             input logic [AW-1:0] a1, input logic [DW-1:0] d1);
    @(negedge clk); wr = 1'b1; addr = a0; wdata = d0;
    @(negedge clk); addr = a1; wdata = d1;
    @(negedge clk); wr = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  typedef struct packed {
    logic [7:0]  a;
    logic [15:0] d;
    logic [2:0]  kind;
    logic [3:0]  ch;
    logic [31:0] exp;
  } vec_t;

  // kind: 0 slew, 1 code inc, 2 carrier inc, 3 code phase, 4 carrier cycle
  localparam vec_t VT [17] = '{
    '{8'h10, 16'h1234, 3'd0, 4'd2,  32'h0000_1234},  // R2 channel write
    '{8'h60, 16'hA5A5, 3'd0, 4'd0,  32'h0000_A5A5},  // R6 broadcast
    '{8'h72, 16'h0022, 3'd0, 4'd1,  32'h0000_A5A5},  // R7 select ch1, ch5
    '{8'h68, 16'h5A5A, 3'd0, 4'd5,  32'h0000_5A5A},  // R7 multi write
    '{8'h3B, 16'hDEAD, 3'd2, 4'd7,  32'h0000_0000},  // R3 high alone
    '{8'h3C, 16'hBEEF, 3'd2, 4'd7,  32'hDEAD_BEEF},  // R3 low commits
    '{8'h25, 16'h0001, 3'd1, 4'd4,  32'h0000_0000},  // R3 code high
    '{8'h26, 16'h0002, 3'd1, 4'd4,  32'h0001_0002},  // R3 code low
    '{8'h25, 16'h1111, 3'd1, 4'd4,  32'h0001_0002},  // R4 stage
    '{8'h18, 16'h7777, 3'd0, 4'd3,  32'h0000_7777},  // R4 intervening write
    '{8'h26, 16'h2222, 3'd1, 4'd4,  32'h0001_0002},  // R4 orphan low ignored
    '{8'h29, 16'h4444, 3'd3, 4'd5,  32'h0000_0000},  // R8 gated off
    '{8'h71, 16'h0008, 3'd3, 4'd5,  32'h0000_0000},  // R8 enable test
    '{8'h29, 16'h4444, 3'd3, 4'd5,  32'h0000_4444},  // R8 preload taken
    '{8'h32, 16'h9999, 3'd4, 4'd6,  32'h0000_9999},  // R8 carrier preload
    '{8'h63, 16'hCAFE, 3'd2, 4'd0,  32'h0000_0000},  // R6 broadcast high
    '{8'h64, 16'hF00D, 3'd2, 4'd11, 32'hCAFE_F00D}   // R6 broadcast low
  };

  bit done = 1'b0;
  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < NCH; i++) begin
      fa[i*FW +: FW] = FW'(i + 1);
      fb[i*FW +: FW] = FW'(i + 'h10);
      fc[i*FW +: FW] = FW'('h80 | i);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 slew", field(0, 0), 32'h0);
    chk("R1 code inc", field(1, 11), 32'h0);
    chk("R1 strobes", {20'h0, cph_ld | ccy_ld | aclr}, 32'h0);
    chk("R1 rdata", {16'h0, rdata}, 32'h0);
    bus_rd(8'h00, v);
    chk("R1 status A", {16'h0, v}, 32'h0);

    for (int k = 0; k < 17; k++) begin
      bus_wr(VT[k].a, VT[k].d);
      chk($sformatf("vector %0d", k), field(int'(VT[k].kind), int'(VT[k].ch)), VT[k].exp);
    end

    // R7 unselected channel untouched by multi write
    chk("R7 ch0 slew", field(0, 0), 32'h0000_A5A5);
    chk("R7 ch1 slew", field(0, 1), 32'h0000_5A5A);
    // R8 one-cycle strobes, one each
    chk("R8 cph strobe count", n_cph5, 1);
    chk("R8 ccy strobe count", n_ccy6, 1);

    // R2 neighbours unchanged
    bus_wr(8'h48, 16'h0909);
    chk("R2 ch9", field(0, 9), 32'h0000_0909);
    chk("R2 ch8", field(0, 8), 32'h0000_A5A5);
    chk("R2 ch10", field(0, 10), 32'h0000_A5A5);

    // R5 shared high, low immediately after
    bus_wr_pair(8'h73, 16'hABCD, 8'h56, 16'h1357);
    chk("R5 code ch10", field(1, 10), 32'hABCD_1357);
    chk("R5 carrier ch10 kept", field(2, 10), 32'hCAFE_F00D);
    bus_wr_pair(8'h73, 16'hABCD, 8'h6C, 16'h2468);
    chk("R5 multi ch1", field(2, 1), 32'hABCD_2468);
    chk("R5 multi ch5", field(2, 5), 32'hABCD_2468);
    chk("R5 unselected ch0", field(2, 0), 32'hCAFE_F00D);

    // R8 test off again
    bus_wr(8'h71, 16'h0000);
    bus_wr(8'h32, 16'h0001);
    chk("R8 gated ccy kept", field(4, 6), 32'h0000_9999);
    chk("R8 no new strobe", n_ccy6, 1);

    // R10 status latch
    bus_wr(8'h70, 16'hFFFF);
    for (int i = 0; i < NCH; i++) fa[i*FW +: FW] = 8'h55;
    bus_rd(8'h18, v); chk("R10 ch3 A", {16'h0, v}, 32'h4);
    bus_rd(8'h19, v); chk("R10 ch3 B", {16'h0, v}, 32'h13);
    bus_rd(8'h1A, v); chk("R10 ch3 C", {16'h0, v}, 32'h83);
    bus_rd(8'h5A, v); chk("R10 ch11 C", {16'h0, v}, 32'h8B);
    bus_rd(8'h20, v); chk("R10 ch4 A held", {16'h0, v}, 32'h5);

    // R9 accumulator status clear
    bus_wr(8'h1F, 16'h0000);
    bus_rd(8'h18, v); chk("R9 ch3 A", {16'h0, v}, 32'h0);
    bus_rd(8'h1A, v); chk("R9 ch3 C", {16'h0, v}, 32'h0);
    bus_rd(8'h20, v); chk("R9 ch4 A kept", {16'h0, v}, 32'h5);
    chk("R9 ch3 strobe", n_clr3, 1);
    chk("R9 ch4 no strobe", n_clr4, 0);

    // R11 read map zeros
    bus_rd(8'h60, v); chk("R11 broadcast read", {16'h0, v}, 32'h0);
    bus_rd(8'h1D, v); chk("R11 unmapped offset", {16'h0, v}, 32'h0);
    bus_rd(8'h72, v); chk("R11 global read", {16'h0, v}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule